// File: doc/BRIEF.md
# Sigma-Delta Capacitive Sense Counter

This block is the digital half of a sigma-delta touch sensor. It produces the switching pattern that drives a sense capacitor and measures the result. The drive pattern comes from a maximal-length linear feedback shift register. The register advances on an enable pulse from a power-of-two prescaler, and it runs in either a 9-bit mode with a 511-step period or a 10-bit mode with a 1023-step period.

While the block is armed, a 16-bit counter adds one for every system-clock cycle in which two things hold: the resynchronised comparator reads high, and the timer's start input is high. Each measurement window is exactly one full sequence period. At the end of a window the block publishes the total, pulses a flag for one cycle, and starts the next window from zero.

Software arms the block through an 8-bit control word. Bit 0 is the enable and bit 3 is the sigma-delta mode; both must be set. The comparator, current source and capacitors are outside the block.

Top module: `sd_sense_counter`

## Requirements
- R1: The block is active only when ctrl_i bit 0 and ctrl_i bit 3 are both 1. While it is inactive, done_o stays 0, count_o holds its last value, and sense_drv_o is 0.
- R2: cmp_async_i passes through two flops before use. The comparator value sampled at clock edge e decides the increment at edge e+2.
- R3: In an active cycle the accumulator adds one only when the synchronised comparator and start_i are both 1. Otherwise it holds.
- R4: A window lasts L·D active system-clock cycles, counted from the first active cycle. L is 511 when ctrl_i bit 1 is 0 and 1023 when it is 1, and D is the prescale divide. At the window's last cycle, the total including that cycle is loaded into count_o. done_o is then 1 for exactly one cycle, while count_o holds the new total.
- R5: The prescale field ctrl_i[7:4] selects a divide D of 2^n for n from 0 to 8. Values above 8 give 256.
- R6: sense_drv_o is the output of a maximal-length sequence. Over any 511 consecutive steps in short mode it is 1 exactly 256 times, and over any 1023 steps in long mode exactly 512 times. It changes only on prescaler pulses.
- R7: The accumulator saturates at 65535 and does not wrap.
- R8: The accumulator is cleared at the start of each window, so back-to-back windows report independent totals.
- R9: After reset, count_o is 0, done_o is 0 and sense_drv_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_async_i | input | 1 | Comparator output, asynchronous to clk_i |
| start_i | input | 1 | Timer start gate, synchronous |
| ctrl_i | input | 8 | Control: bit0 enable, bit1 long sequence, bit3 sigma-delta mode, [7:4] prescale |
| sense_drv_o | output | 1 | Sense-capacitor switch drive |
| count_o | output | 16 | Total of the last completed window |
| done_o | output | 1 | One-cycle pulse when count_o is updated |

## Verification
The assertions assume that ctrl_i changes only while the block is inactive, or together with the transition into or out of the active state. They also assume that start_i is synchronous to clk_i. The stimulus respects both assumptions: it drives every input at the falling edge, and it changes the control word only when entering or leaving a run of windows. The comparator input is the only signal treated as asynchronous. The bench predicts the count from the comparator value two edges earlier, which is the latency the synchroniser defines.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int CTRL_W     = 8;
  localparam int EN_BIT     = 0;
  localparam int LONG_BIT   = 1;
  localparam int MODE_BIT   = 3;
  localparam int PS_LSB     = 4;
  localparam int PS_W       = 4;
  localparam int PS_MAX_LOG = 8;
  localparam int SHORT_N    = 9;
  localparam int SHORT_TAP  = 5;
  localparam int LONG_N     = 10;
  localparam int LONG_TAP   = 7;

  typedef struct packed {
    logic             active;
    logic             long_seq;
    logic [PS_W-1:0]  psel;
  } sd_cfg_t;

  function automatic sd_cfg_t decode_ctrl(input logic [CTRL_W-1:0] c);
    sd_cfg_t r;
    r.active   = c[EN_BIT] & c[MODE_BIT];
    r.long_seq = c[LONG_BIT];
    r.psel     = c[PS_LSB +: PS_W];
    return r;
  endfunction
endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sd_prescaler.sv
module sd_prescaler #(
  parameter int SEL_W   = 4,
  parameter int MAX_LOG = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [SEL_W-1:0] sel_c;

  always_comb begin
    sel_c = (sel_i > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : sel_i;
    lim   = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << sel_c) - 1'b1);
  end

  assign tick_o = active_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!active_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sd_prs.sv
module sd_prs #(
  parameter int SHORT_N   = 9,
  parameter int SHORT_TAP = 5,
  parameter int LONG_N    = 10,
  parameter int LONG_TAP  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic long_i,
  input  logic tick_i,
  output logic drv_o,
  output logic wrap_o
);
  localparam logic [LONG_N-1:0] SEED      = LONG_N'(1);
  localparam logic [LONG_N-1:0] SHORT_END = LONG_N'((1 << SHORT_N) - 2);
  localparam logic [LONG_N-1:0] LONG_END  = LONG_N'((1 << LONG_N) - 2);

  logic [LONG_N-1:0] st_q, st_d;
  logic [LONG_N-1:0] step_q;
  logic [LONG_N-1:0] last_step;
  logic              fb;

  always_comb begin
    st_d = '0;
    if (long_i) begin
      fb   = st_q[LONG_N-1] ^ st_q[LONG_TAP-1];
      st_d = {st_q[LONG_N-2:0], fb};
    end else begin
      fb                = st_q[SHORT_N-1] ^ st_q[SHORT_TAP-1];
      st_d[SHORT_N-1:0] = {st_q[SHORT_N-2:0], fb};
    end
    last_step = long_i ? LONG_END : SHORT_END;
  end

  assign wrap_o = tick_i && (step_q == last_step);
  assign drv_o  = active_i && (long_i ? st_q[LONG_N-1] : st_q[SHORT_N-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEED;
      step_q <= '0;
    end else if (!active_i) begin
      st_q   <= SEED;
      step_q <= '0;
    end else if (tick_i) begin
      st_q   <= st_d;
      step_q <= wrap_o ? '0 : step_q + 1'b1;
    end
  end
endmodule

// File: rtl/sd_accum.sv
module sd_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             inc_i,
  input  logic             wend_i,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] acc_q, acc_nxt, count_q;
  logic             done_q;

  always_comb begin
    acc_nxt = acc_q;
    if (inc_i && acc_q != MAX) acc_nxt = acc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= wend_i;
      if (!active_i) begin
        acc_q <= '0;
      end else if (wend_i) begin
        count_q <= acc_nxt;
        acc_q   <= '0;
      end else begin
        acc_q <= acc_nxt;
      end
    end
  end

  assign acc_o   = acc_q;
  assign count_o = count_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sd_sense_counter.sv
module sd_sense_counter
  import sd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_async_i,
  input  logic              start_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              sense_drv_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              done_o
);
  sd_cfg_t          cfg;
  logic             cmp_sync;
  logic             tick;
  logic             wend;
  logic             inc;
  logic [CNT_W-1:0] acc;

  assign cfg = decode_ctrl(ctrl_i);
  assign inc = cfg.active && cmp_sync && start_i;

  sd_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_async_i),
    .q_o    (cmp_sync)
  );

  sd_prescaler #(.SEL_W(PS_W), .MAX_LOG(PS_MAX_LOG)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (cfg.active),
    .sel_i    (cfg.psel),
    .tick_o   (tick)
  );

  sd_prs #(
    .SHORT_N(SHORT_N), .SHORT_TAP(SHORT_TAP),
    .LONG_N(LONG_N),   .LONG_TAP(LONG_TAP)
  ) u_prs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (cfg.active),
    .long_i   (cfg.long_seq),
    .tick_i   (tick),
    .drv_o    (sense_drv_o),
    .wrap_o   (wend)
  );

  sd_accum #(.CNT_W(CNT_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (cfg.active),
    .inc_i    (inc),
    .wend_i   (wend),
    .acc_o    (acc),
    .count_o  (count_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/sd_sense_counter_chk.sv
module sd_sense_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active,
  input logic             tick,
  input logic             inc,
  input logic             wend,
  input logic [CNT_W-1:0] acc,
  input logic             sense_drv_o,
  input logic             done_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (!done_o && !sense_drv_o));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !inc && !wend) |=> $stable(acc));

  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_drive_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !tick) |=> $stable(sense_drv_o));

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && acc == MAX && !wend) |=> (acc == MAX));

  a_r8_clear_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wend |=> (acc == '0));
endmodule

bind sd_sense_counter sd_sense_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active      (cfg.active),
  .tick        (tick),
  .inc         (inc),
  .wend        (wend),
  .acc         (acc),
  .sense_drv_o (sense_drv_o),
  .done_o      (done_o)
);

// File: tb/sd_sense_counter_tb_top.sv
module sd_sense_counter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp_async_i = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  ctrl_i = 8'h00;
  logic        sense_drv_o;
  logic [15:0] count_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  logic done_prev = 1'b0;

  always #4 clk_i = ~clk_i;

  sd_sense_counter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_async_i(cmp_async_i),
    .start_i(start_i), .ctrl_i(ctrl_i), .sense_drv_o(sense_drv_o),
    .count_o(count_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit f_cmp(input int p, input int c);
    case (p)
      1:       return 1'b0;
      3:       return c[0];
      4:       return (c % 3) == 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit f_st(input int p, input int c);
    case (p)
      2:       return 1'b0;
      4:       return (c % 5) != 0;
      default: return 1'b1;
    endcase
  endfunction

  // scoreboard monitor: R4 count at done, one-cycle pulse
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected done", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(count_o == 16'(e), "R4/R3/R2 window count", count_o, e);
        end
        check(!done_prev, "R4 done single cycle", 1, 0);
      end
      done_prev <= done_o;
    end
  end

  task automatic run(input bit lng, input int psel, input int pat, input int nwin, input bit chk_drv);
    int len, dv, n, ones;
    len  = lng ? 1023 : 511;
    dv   = 1 << psel;
    n    = len * dv;
    ones = 0;
    for (int w = 0; w < nwin; w++) begin
      int s;
      s = 0;
      for (int c = w * n; c < (w + 1) * n; c++)
        if (f_cmp(pat, c - 2) && f_st(pat, c)) s++;
      if (s > 65535) s = 65535; // R7
      exp_q.push_back(s);
    end
    @(negedge clk_i);
    ctrl_i = 8'h00;
    repeat (3) @(negedge clk_i);
    for (int c = -2; c <= nwin * n; c++) begin
      @(negedge clk_i);
      if (c >= 1 && c <= n) ones += int'(sense_drv_o);
      if (c == 0) ctrl_i = 8'h09 | (8'(lng) << 1) | (8'(psel) << 4);
      cmp_async_i = f_cmp(pat, c);
      start_i     = f_st(pat, c);
    end
    @(negedge clk_i);
    ctrl_i = 8'h00;
    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R4 all windows reported", exp_q.size(), 0);
    if (chk_drv) check(ones == (len + 1) / 2, "R6 sequence ones per period", ones, (len + 1) / 2);
  endtask

  task automatic idle_probe(input logic [7:0] cv, input string req);
    logic [15:0] held;
    int dn, dr;
    held = count_o;
    dn = 0;
    dr = 0;
    @(negedge clk_i);
    ctrl_i = cv;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_i);
      cmp_async_i = i[0];
      start_i = 1'b1;
      dn += int'(done_o);
      dr += int'(sense_drv_o);
    end
    check(dn == 0, {req, " no done"}, dn, 0);
    check(dr == 0, {req, " drive low"}, dr, 0);
    check(count_o == held, {req, " count held"}, count_o, held);
    ctrl_i = 8'h00;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(count_o == 0, "R9 count reset", count_o, 0);
    check(done_o == 0, "R9 done reset", done_o, 0);
    check(sense_drv_o == 0, "R9 drive reset", sense_drv_o, 0);
    rst_ni = 1'b1;
    run(1'b0, 0, 0, 1, 1'b1);   // R4 R6 short div1 full count
    run(1'b1, 0, 0, 1, 1'b1);   // R4 R6 long div1
    run(1'b0, 0, 1, 1, 1'b0);   // R3 comparator low
    run(1'b0, 0, 2, 1, 1'b0);   // R3 start low
    run(1'b0, 2, 3, 1, 1'b0);   // R2 R5 toggling, div4
    run(1'b1, 1, 4, 1, 1'b0);   // R2 R3 R5 mixed, div2
    run(1'b0, 3, 4, 2, 1'b0);   // R8 back-to-back windows, div8
    idle_probe(8'h00, "R1 disabled");
    idle_probe(8'h01, "R1 enable without mode");
    idle_probe(8'h08, "R1 mode without enable");
    run(1'b1, 7, 0, 1, 1'b0);   // R7 saturation, R5 div128
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule